// File: doc/BRIEF.md
# Dual-Fanout Registered Address Buffer

This block is the register stage on a memory module's command and address path. On each rising clock edge it captures 22 data bits, two chip-select bits, two clock-enable bits and two on-die-termination bits. Each captured bit drives two output copies, A and B, and the two copies always carry the same value. Each copy has its own flop bank, so the load on each output net is split in two.

Chip-select gating can be switched on with the gate-enable input. When gating is on and both active-low chip selects are high, neither rank is addressed. The 22 data outputs then keep their previous value, which saves switching power on the module. The chip-select, clock-enable and termination outputs keep updating every cycle.

A parity checker takes one parity input with each data word. It uses even parity over the 22 data bits plus the parity bit. The result is reported on a registered, active-low error flag. An asynchronous active-low reset clears every register at once. Every output goes low during reset except the error flag, which sits high (no error).

Top module: `dual_fanout_addr_buf`

## Requirements
- R1: Every A output equals its B counterpart on every cycle.
- R2: After each rising clock edge out of reset, the chip-select, clock-enable and termination outputs equal the values their inputs had at that edge.
- R3: If gate_en_i is 1 and cs_n_i is 2'b11 at an edge, the data outputs keep the values they held before that edge.
- R4: If gate_en_i is 1 and at least one bit of cs_n_i is 0 at an edge, the data outputs take data_i from that edge.
- R5: If gate_en_i is 0, the data outputs take data_i at every edge, whatever the value of cs_n_i.
- R6: Gating never freezes the chip-select, clock-enable or termination outputs.
- R7: Parity is even over data_i and par_i. An odd count of ones at edge k drives par_err_no to 0 after edge k+1; an even count drives it to 1. The flag is 0 only in cycles that follow a mismatching capture.
- R8: While rst_ni is 0, every data and control output is 0 and par_err_no is 1, without waiting for a clock edge.
- R9: Reset overrides gating. After rst_ni rises, with all inputs held at 0 and the clock running, every output stays 0 and par_err_no stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | 1 enables chip-select gating of data outputs |
| data_i | input | 22 | Address/command data bits |
| cs_n_i | input | 2 | Active-low rank chip selects |
| cke_i | input | 2 | Clock-enable bits |
| odt_i | input | 2 | On-die-termination bits |
| par_i | input | 1 | Parity bit for data_i, even parity |
| data_a_o | output | 22 | Registered data, copy A |
| data_b_o | output | 22 | Registered data, copy B |
| cs_n_a_o | output | 2 | Registered chip selects, copy A |
| cs_n_b_o | output | 2 | Registered chip selects, copy B |
| cke_a_o | output | 2 | Registered clock enables, copy A |
| cke_b_o | output | 2 | Registered clock enables, copy B |
| odt_a_o | output | 2 | Registered termination bits, copy A |
| odt_b_o | output | 2 | Registered termination bits, copy B |
| par_err_no | output | 1 | Registered parity error flag, active low |

## Verification
The assertions assume that every input is stable and known at each rising edge. The bench meets this by driving all inputs on the falling edge only. The reset checks assume that rst_ni may fall at any time but rises only away from a rising edge; the bench drops reset in the middle of a cycle to exercise the asynchronous path, and raises it on a falling edge. The parity window checks allow for a clean start after reset: they are gated until one edge has passed since reset, so captures made while in reset are never compared.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  localparam int unsigned DATA_W  = 22;
  localparam int unsigned RANK_W  = 2;
  localparam int unsigned N_COPY  = 2;

  typedef struct packed {
    logic [RANK_W-1:0] cs_n;
    logic [RANK_W-1:0] cke;
    logic [RANK_W-1:0] odt;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/abuf_bank.sv
module abuf_bank #(
  parameter int unsigned W      = 22,
  parameter int unsigned NCOPY  = 2,
  parameter bit          GATED  = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hold_i,
  input  logic [W-1:0]              d_i,
  output logic [NCOPY-1:0][W-1:0]   q_o
);
  logic hold_eff;
  assign hold_eff = GATED && hold_i;

  // One flop bank per copy so each output net has its own driver.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q <= '0;
      else if (!hold_eff) q_q <= d_i;
    end
    assign q_o[c] = q_q;

    // R3
    hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_eff |=> $stable(q_o[c]));
    // R4
    capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hold_eff |=> q_o[c] == $past(d_i));
  end
endmodule

// File: rtl/abuf_parity.sv
module abuf_parity #(
  parameter int unsigned W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         par_i,
  output logic         err_no
);
  logic mis_q;   // 1 = odd count seen at capture
  logic err_nq;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mis_q  <= 1'b0;
      err_nq <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      mis_q  <= (^d_i) ^ par_i;
      err_nq <= ~mis_q;
      seen_q <= 1'b1;
    end
  end
  assign err_no = err_nq;

  // R7
  mis_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> mis_q == $past((^d_i) ^ par_i));
  // R7
  flag_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> err_no == !$past(mis_q));
endmodule

// File: rtl/dual_fanout_addr_buf.sv
module dual_fanout_addr_buf
  import abuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [RANK_W-1:0] cs_n_i,
  input  logic [RANK_W-1:0] cke_i,
  input  logic [RANK_W-1:0] odt_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] data_a_o,
  output logic [DATA_W-1:0] data_b_o,
  output logic [RANK_W-1:0] cs_n_a_o,
  output logic [RANK_W-1:0] cs_n_b_o,
  output logic [RANK_W-1:0] cke_a_o,
  output logic [RANK_W-1:0] cke_b_o,
  output logic [RANK_W-1:0] odt_a_o,
  output logic [RANK_W-1:0] odt_b_o,
  output logic              par_err_no
);
  logic                           hold;
  ctrl_t                          ctrl_in;
  logic [N_COPY-1:0][DATA_W-1:0]  data_q;
  logic [N_COPY-1:0][CTRL_W-1:0]  ctrl_q;
  ctrl_t                          ctrl_a, ctrl_b;

  // No rank selected: freeze the data lanes.
  assign hold = gate_en_i & (&cs_n_i);

  assign ctrl_in.cs_n = cs_n_i;
  assign ctrl_in.cke  = cke_i;
  assign ctrl_in.odt  = odt_i;

  abuf_bank #(.W(DATA_W), .NCOPY(N_COPY), .GATED(1'b1)) u_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .d_i   (data_i),
    .q_o   (data_q)
  );

  abuf_bank #(.W(CTRL_W), .NCOPY(N_COPY), .GATED(1'b0)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .d_i   (ctrl_in),
    .q_o   (ctrl_q)
  );

  abuf_parity #(.W(DATA_W)) u_par (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .par_i (par_i),
    .err_no(par_err_no)
  );

  assign ctrl_a   = ctrl_t'(ctrl_q[0]);
  assign ctrl_b   = ctrl_t'(ctrl_q[1]);
  assign data_a_o = data_q[0];
  assign data_b_o = data_q[1];
  assign cs_n_a_o = ctrl_a.cs_n;
  assign cs_n_b_o = ctrl_b.cs_n;
  assign cke_a_o  = ctrl_a.cke;
  assign cke_b_o  = ctrl_b.cke;
  assign odt_a_o  = ctrl_a.odt;
  assign odt_b_o  = ctrl_b.odt;

  // R1
  copies_match_chk: assert property (@(posedge clk_i)
    data_a_o == data_b_o && cs_n_a_o == cs_n_b_o &&
    cke_a_o == cke_b_o && odt_a_o == odt_b_o);
  // R6
  ctrl_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> cs_n_a_o == $past(cs_n_i) && cke_a_o == $past(cke_i) &&
             odt_a_o == $past(odt_i));
  // R8
  reset_state_chk: assert property (@(negedge clk_i)
    !rst_ni |-> data_a_o == '0 && cs_n_a_o == '0 && cke_a_o == '0 &&
                odt_a_o == '0 && par_err_no);
endmodule

// File: tb/tb_dual_fanout_addr_buf.sv
module tb_dual_fanout_addr_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gate_en_i = 1'b0;
  logic [21:0] data_i = '0;
  logic [1:0]  cs_n_i = '0, cke_i = '0, odt_i = '0;
  logic        par_i = 1'b0;
  logic [21:0] data_a_o, data_b_o;
  logic [1:0]  cs_n_a_o, cs_n_b_o, cke_a_o, cke_b_o, odt_a_o, odt_b_o;
  logic        par_err_no;

  int checks = 0, errors = 0;
  logic [21:0] m_data = '0;
  logic [1:0]  m_cs = '0, m_cke = '0, m_odt = '0;
  logic        m_err_n = 1'b1, m_pend = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_fanout_addr_buf dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string dreq);
    chk(dreq, 32'(data_a_o), 32'(m_data));
    chk("R1", 32'(data_b_o), 32'(data_a_o));
    chk("R1", 32'({cs_n_b_o, cke_b_o, odt_b_o}), 32'({cs_n_a_o, cke_a_o, odt_a_o}));
    chk("R2", 32'({cs_n_a_o, cke_a_o, odt_a_o}), 32'({m_cs, m_cke, m_odt}));
    chk("R7", 32'(par_err_no), 32'(m_err_n));
  endtask

  // Inputs already set after a falling edge; run one rising edge and compare.
  task automatic tick();
    string dreq;
    @(posedge clk_i);
    if (gate_en_i && cs_n_i == 2'b11) dreq = "R3";
    else if (gate_en_i) dreq = "R4";
    else dreq = "R5";
    if (gate_en_i && cs_n_i == 2'b11) dreq = "R3";
    if (!(gate_en_i && cs_n_i == 2'b11)) m_data = data_i;
    if (gate_en_i && cs_n_i == 2'b11) dreq = "R6";
    m_cs = cs_n_i; m_cke = cke_i; m_odt = odt_i;
    m_err_n = ~m_pend;
    m_pend = (^data_i) ^ par_i;
    #1;
    check_all((gate_en_i && cs_n_i == 2'b11) ? "R3" : (gate_en_i ? "R4" : "R5"));
    @(negedge clk_i);
  endtask

  task automatic drive_rand(input logic gate, input int cs_mode);
    gate_en_i = gate;
    data_i = 22'($urandom);
    par_i = 1'($urandom);
    cke_i = 2'($urandom);
    odt_i = 2'($urandom);
    cs_n_i = (cs_mode == 1) ? 2'b11 : (cs_mode == 0) ? 2'($urandom) : 2'($urandom % 3);
  endtask

  task automatic model_reset();
    m_data = '0; m_cs = '0; m_cke = '0; m_odt = '0; m_err_n = 1'b1; m_pend = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state with active inputs
    data_i = '1; cs_n_i = 2'b01; cke_i = 2'b11; odt_i = 2'b11; par_i = 1'b1;
    repeat (3) @(negedge clk_i);
    model_reset();
    check_all("R8");
    data_i = '0; cs_n_i = '0; cke_i = '0; odt_i = '0; par_i = 1'b0;
    rst_ni = 1'b1;
    // R9: zero inputs out of reset keep outputs low
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R9", 32'({data_a_o, cs_n_a_o, cke_a_o, odt_a_o}), 32'h0);
      chk("R9", 32'(par_err_no), 32'h1);
    end
    // R7 directed: one odd word, one even word
    data_i = 22'h000001; par_i = 1'b0; tick();
    data_i = 22'h000003; par_i = 1'b0; tick();
    chk("R7", 32'(par_err_no), 32'h0);
    data_i = 22'h000000; tick();
    chk("R7", 32'(par_err_no), 32'h1);
    // R3/R6 directed hold
    gate_en_i = 1'b0; cs_n_i = 2'b00; data_i = 22'h2aaaaa; tick();
    gate_en_i = 1'b1; cs_n_i = 2'b11; data_i = 22'h155555; cke_i = 2'b10; tick();
    chk("R3", 32'(data_a_o), 32'h2aaaaa);
    chk("R6", 32'(cke_a_o), 32'h2);
    // R5 directed: gating off with both selects high
    gate_en_i = 1'b0; tick();
    chk("R5", 32'(data_a_o), 32'h155555);
    // Random phases
    for (int i = 0; i < 300; i++) begin drive_rand(1'b1, 0); tick(); end
    for (int i = 0; i < 100; i++) begin drive_rand(1'b1, 2); tick(); end
    for (int i = 0; i < 100; i++) begin drive_rand(1'b1, 1); tick(); end
    for (int i = 0; i < 200; i++) begin drive_rand(1'b0, 0); tick(); end
    // R8/R9: async reset mid-cycle while gating holds
    drive_rand(1'b1, 1);
    #1 rst_ni = 1'b0;
    #0.5;
    model_reset();
    check_all("R8");
    chk("R9", 32'(data_a_o), 32'h0);
    @(negedge clk_i);
    data_i = '0; cs_n_i = '0; cke_i = '0; odt_i = '0; par_i = 1'b0; gate_en_i = 1'b1;
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9", 32'({data_a_o, cs_n_a_o, cke_a_o, odt_a_o, par_err_no}), 32'h1);
    end
    for (int i = 0; i < 100; i++) begin drive_rand(1'($urandom), 0); tick(); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule